// File: doc/BRIEF.md
# Raycast Column Engine

This block draws a first-person 2.5D view of a small tile map, one screen column at a time. A single start pulse captures the player's position and viewing angle. The block then casts one ray for each of the 160 display columns, from left to right. Each ray's direction comes from the viewing angle plus a per-column offset, read from a sine quarter-wave table. The ray walks a 16×16 map held inside the block, one grid line at a time, until it enters a solid cell.

The distance along the viewing axis to that cell is turned into a wall-slice height. A reciprocal table followed by a multiply does this conversion. The cell's value gives a 4-bit base intensity, which is dimmed in steps as the distance grows. Walls crossed on a horizontal grid line get one extra step of dimming. For each column the block emits one result beat that carries the column number, height, shade and wall code. A frame-done pulse follows the last column.

A display pipeline consumes the stream and paints columns into a frame store. The block has no knowledge of scan timing.

Top module: `raycol_engine`

## Requirements
- R1: While reset is held and after its release, with no start yet given, `col_valid` and `frame_done` stay 0 and `col_height`, `col_shade` and `col_wall` read 0.
- R2: A `start` pulse while idle produces exactly 160 result beats. Each beat is a single-cycle `col_valid`, and `col_num` counts 0, 1, …, 159 in order.
- R3: `frame_done` is high for exactly one cycle: the cycle right after the beat for column 159.
- R4: Angles use 256 units per turn. The ray angle for column c is (view_ang + floor(c/4) − 20) mod 256. Sine magnitude uses a quarter-wave table: q(i) = floor(2032·i·(128−i) / (81920 − 4·i·(128−i))) for i in 0..64. For angle a with i = a mod 64: the magnitude is q(64−i) when bit 6 of a is set and q(i) otherwise, and the sign is negative when bit 7 is set. Cosine(a) is sine(a+64).
- R5: Positions are unsigned Q4.8 in cell units. The map cell (x,y) holds 9 when x is 0 or 15, otherwise 12 when y is 0 or 15, otherwise 6 when x mod 4 = 2 and y mod 4 = 2, otherwise 0. At each step the ray advances in x when side_x < side_y and in y otherwise (so a tie steps in y). Cell coordinates wrap modulo 16. The walk ends at the first cell with a non-zero value, and that value is reported on `col_wall`.
- R6: The per-axis delta is 32512/m (integer) for a direction magnitude m, and 65535 when m = 0. The initial side distance is (g·delta)>>8. Here g is the fractional part of the position when that axis steps negative, and 256 minus the fractional part otherwise. The perpendicular distance d is the side distance of the crossing axis taken before its final increment, saturated to 65535.
- R7: If d ≥ 4096 the index k is 63; otherwise k = d>>6. The height is 120 when k = 0. Otherwise it is min(120, (240·floor(4096/k))>>12).
- R8: The distance band is 3 if d ≥ 4096 and (d>>10) otherwise. The shade is the wall code shifted right by the band, plus one more bit when the final crossing was a y step.
- R9: A ray that has taken 32 steps without entering a solid cell ends there, and its beat carries wall code 0, height 0 and shade 0. The limit is the `STEP_LIMIT` parameter.
- R10: Position and angle are captured on the accepted start. A change on these inputs, or another start pulse, while a frame is in progress has no effect on that frame and does not start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a frame (honoured only when idle) |
| pos_x | input | 12 | Player x, Q4.8 cells |
| pos_y | input | 12 | Player y, Q4.8 cells |
| view_ang | input | 8 | Viewing angle, 256 units per turn |
| col_valid | output | 1 | One-cycle result beat |
| col_num | output | 8 | Column index of the beat |
| col_height | output | 7 | Wall slice height in rows (0..120) |
| col_shade | output | 4 | Distance-dimmed intensity |
| col_wall | output | 4 | Code of the wall cell hit (0 on step limit) |
| frame_done | output | 1 | One-cycle pulse after column 159 |

## Verification
The assertions assume the player stands inside an empty cell, so every ray meets the solid border within the step limit. Under that assumption the wall code is zero only on a forced stop. The assertions also assume `start` is a pulse, and that beat ordering depends only on the engine's own sequencing. The stimulus keeps to this by placing the player in empty interior cells, including one on an exact grid corner and one a few fractions of a cell from a pillar. The step-limit behaviour is exercised on a second instance with a limit of 3. A start pulse and new inputs are injected in the middle of a frame to show they are ignored.

// File: rtl/raycol_pkg.sv
`timescale 1ns/1ps
// Shared constants, table generators and the sequencer state type for the
// raycast column engine. Assumes a 16x16 map and Q4.8 positions.
package raycol_pkg;
    localparam int MAP_N   = 16;
    localparam int CELL_W  = 4;
    localparam int FRAC_W  = 8;
    localparam int POS_W   = CELL_W + FRAC_W;
    localparam int MAG_W   = 7;
    localparam int DELTA_W = 16;
    localparam int DIST_W  = 16;
    localparam int SIDE_W  = 22;
    localparam int INV_N   = 64;
    localparam int INV_W   = 13;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_FINISH
    } seq_state_t;

    // Quarter-wave sine magnitude scaled to 127 (rational approximation).
    function automatic logic [MAG_W-1:0] quarter_mag(input int i);
        int p;
        p = i * (128 - i);
        return MAG_W'((2032 * p) / (81920 - 4 * p));
    endfunction

    // Cells-per-unit-direction step length in Q8.8, saturated for m = 0.
    function automatic logic [DELTA_W-1:0] delta_of(input int m);
        if (m == 0) return '1;
        return DELTA_W'(32512 / m);
    endfunction

    // Reciprocal of a quarter-cell distance index, scaled by 4096.
    function automatic logic [INV_W-1:0] inv_of(input int k);
        if (k == 0) return '0;
        return INV_W'(4096 / k);
    endfunction

    // Fixed map: solid border, pillars on a 4-cell lattice.
    function automatic logic [CELL_W-1:0] map_cell(input int x, input int y);
        if (x == 0 || x == MAP_N - 1) return CELL_W'(9);
        if (y == 0 || y == MAP_N - 1) return CELL_W'(12);
        if ((x % 4) == 2 && (y % 4) == 2) return CELL_W'(6);
        return '0;
    endfunction
endpackage

// File: rtl/raycol_trig.sv
`timescale 1ns/1ps
// Ray direction lookup: turns a ray angle (256 units per turn) into the
// magnitude and sign of its sine and cosine. Purely combinational; the
// quarter-wave table is built at elaboration.
module raycol_trig
    import raycol_pkg::*;
(
    input  logic [7:0]       ray_ang,
    output logic [MAG_W-1:0] sin_mag,
    output logic             sin_neg,
    output logic [MAG_W-1:0] cos_mag,
    output logic             cos_neg
);
    localparam int QTAB_N = 65;

    logic [MAG_W-1:0] qtab [0:QTAB_N-1];
    logic [7:0]       ch_ang [2];
    logic [MAG_W-1:0] ch_mag [2];
    logic             ch_neg [2];

    // Quarter-wave table contents.
    for (genvar i = 0; i < QTAB_N; i++) begin : g_qtab
        assign qtab[i] = quarter_mag(i);
    end

    // Channel 0 is sine, channel 1 is cosine (sine advanced by a quarter turn).
    assign ch_ang[0] = ray_ang;
    assign ch_ang[1] = ray_ang + 8'd64;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        logic [6:0] idx;
        // Mirror the index in odd quadrants.
        always_comb begin
            if (ch_ang[c][6]) idx = 7'd64 - {1'b0, ch_ang[c][5:0]};
            else              idx = {1'b0, ch_ang[c][5:0]};
        end
        assign ch_mag[c] = qtab[idx];
        assign ch_neg[c] = ch_ang[c][7];
    end

    assign sin_mag = ch_mag[0];
    assign sin_neg = ch_neg[0];
    assign cos_mag = ch_mag[1];
    assign cos_neg = ch_neg[1];
endmodule

// File: rtl/raycol_walker.sv
`timescale 1ns/1ps
// Grid walker: on go, loads per-axis step lengths and initial side
// distances, then crosses one grid line per cycle until it enters a solid
// cell or reaches STEP_LIMIT steps. Reports the perpendicular distance,
// the crossing axis and the cell code with a one-cycle fin pulse.
// Assumes go arrives only while the walker is idle.
module raycol_walker
    import raycol_pkg::*;
#(
    parameter int STEP_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [POS_W-1:0]  pos_x,
    input  logic [POS_W-1:0]  pos_y,
    input  logic [MAG_W-1:0]  cos_mag,
    input  logic              cos_neg,
    input  logic [MAG_W-1:0]  sin_mag,
    input  logic              sin_neg,
    output logic              fin,
    output logic [DIST_W-1:0] perp,
    output logic              y_side,
    output logic [CELL_W-1:0] hit_id
);
    localparam int STEP_W    = $clog2(STEP_LIMIT + 1);
    localparam int MAP_CELLS = MAP_N * MAP_N;
    localparam int DTAB_N    = 1 << MAG_W;
    localparam int PROD_W    = FRAC_W + DELTA_W + 1;
    localparam logic [FRAC_W:0]   ONE_CELL = (FRAC_W + 1)'(1 << FRAC_W);
    localparam logic [CELL_W-1:0] ONE_IDX  = CELL_W'(1);
    localparam logic [SIDE_W-1:0] DIST_MAX = SIDE_W'((1 << DIST_W) - 1);

    logic [DELTA_W-1:0] dtab   [0:DTAB_N-1];
    logic [CELL_W-1:0]  maptab [0:MAP_CELLS-1];

    // Step-length reciprocal table.
    for (genvar m = 0; m < DTAB_N; m++) begin : g_dtab
        assign dtab[m] = delta_of(m);
    end
    // Map ROM, indexed {y, x}.
    for (genvar k = 0; k < MAP_CELLS; k++) begin : g_map
        assign maptab[k] = map_cell(k % MAP_N, k / MAP_N);
    end

    logic [DELTA_W-1:0] ld_dx, ld_dy;
    logic [FRAC_W:0]    gap_x, gap_y;
    logic [PROD_W-1:0]  prod_x, prod_y;
    logic [SIDE_W-1:0]  side0_x, side0_y;

    // Initial side distances from the fractional position.
    always_comb begin
        ld_dx   = dtab[cos_mag];
        ld_dy   = dtab[sin_mag];
        gap_x   = cos_neg ? {1'b0, pos_x[FRAC_W-1:0]} : ONE_CELL - {1'b0, pos_x[FRAC_W-1:0]};
        gap_y   = sin_neg ? {1'b0, pos_y[FRAC_W-1:0]} : ONE_CELL - {1'b0, pos_y[FRAC_W-1:0]};
        prod_x  = PROD_W'(gap_x) * PROD_W'(ld_dx);
        prod_y  = PROD_W'(gap_y) * PROD_W'(ld_dy);
        side0_x = SIDE_W'(prod_x >> FRAC_W);
        side0_y = SIDE_W'(prod_y >> FRAC_W);
    end

    logic                marching;
    logic [SIDE_W-1:0]   side_x, side_y;
    logic [DELTA_W-1:0]  dx, dy;
    logic [CELL_W-1:0]   cx, cy;
    logic                neg_x, neg_y;
    logic [STEP_W-1:0]   steps;

    logic                take_x;
    logic [CELL_W-1:0]   nx, ny;
    logic [CELL_W-1:0]   look;
    logic [SIDE_W-1:0]   prev;
    logic [DIST_W-1:0]   prev_sat;

    // One DDA step: pick the nearer grid line and probe the next cell.
    always_comb begin
        take_x   = side_x < side_y;
        nx       = take_x ? (neg_x ? cx - ONE_IDX : cx + ONE_IDX) : cx;
        ny       = take_x ? cy : (neg_y ? cy - ONE_IDX : cy + ONE_IDX);
        look     = maptab[{ny, nx}];
        prev     = take_x ? side_x : side_y;
        prev_sat = (prev > DIST_MAX) ? '1 : DIST_W'(prev);
    end

    // Walker state: load on go, advance while marching, report on stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marching <= 1'b0;
            fin      <= 1'b0;
            perp     <= '0;
            y_side   <= 1'b0;
            hit_id   <= '0;
            side_x   <= '0;
            side_y   <= '0;
            dx       <= '0;
            dy       <= '0;
            cx       <= '0;
            cy       <= '0;
            neg_x    <= 1'b0;
            neg_y    <= 1'b0;
            steps    <= '0;
        end else begin
            fin <= 1'b0;
            if (!marching) begin
                if (go) begin
                    side_x   <= side0_x;
                    side_y   <= side0_y;
                    dx       <= ld_dx;
                    dy       <= ld_dy;
                    cx       <= pos_x[POS_W-1:FRAC_W];
                    cy       <= pos_y[POS_W-1:FRAC_W];
                    neg_x    <= cos_neg;
                    neg_y    <= sin_neg;
                    steps    <= '0;
                    marching <= 1'b1;
                end
            end else begin
                if (take_x) side_x <= side_x + SIDE_W'(dx);
                else        side_y <= side_y + SIDE_W'(dy);
                cx    <= nx;
                cy    <= ny;
                steps <= steps + STEP_W'(1);
                if (look != '0 || steps == STEP_W'(STEP_LIMIT - 1)) begin
                    fin      <= 1'b1;
                    marching <= 1'b0;
                    perp     <= prev_sat;
                    y_side   <= !take_x;
                    hit_id   <= look;
                end
            end
        end
    end

    AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        marching |-> steps < STEP_W'(STEP_LIMIT)); // R9
    AST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (marching && look != '0) |=> (fin && !marching)); // R5
    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin); // R2
endmodule

// File: rtl/raycol_shade.sv
`timescale 1ns/1ps
// Height and shade stage: reciprocal lookup plus multiply for the wall
// slice height (clamped to ROWS), distance-banded right shift for the
// shade. Combinational. A zero wall code means no hit and yields 0/0.
module raycol_shade
    import raycol_pkg::*;
#(
    parameter int ROWS = 120,
    parameter int KF   = 240
) (
    input  logic [DIST_W-1:0]          perp,
    input  logic                       y_side,
    input  logic [CELL_W-1:0]          hit_id,
    output logic [$clog2(ROWS+1)-1:0]  height,
    output logic [CELL_W-1:0]          shade
);
    localparam int H_W    = $clog2(ROWS + 1);
    localparam int PROD_W = 24;
    localparam logic [DIST_W-1:0] FAR_DIST = DIST_W'(1 << 12);

    logic [INV_W-1:0] invtab [0:INV_N-1];

    // Reciprocal table of quarter-cell distance indices.
    for (genvar k = 0; k < INV_N; k++) begin : g_inv
        assign invtab[k] = inv_of(k);
    end

    logic              far;
    logic [5:0]        idx;
    logic [1:0]        band;
    logic [2:0]        shift;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] raw_h;

    // Height from k*f/d via reciprocal and multiply, then banded dimming.
    always_comb begin
        far   = perp >= FAR_DIST;
        idx   = far ? 6'd63 : 6'(perp >> 6);
        band  = far ? 2'd3 : 2'(perp >> 10);
        prod  = PROD_W'(KF) * PROD_W'(invtab[idx]);
        raw_h = prod >> 12;
        shift = {1'b0, band} + {2'b0, y_side};
        if (hit_id == '0) begin
            height = '0;
            shade  = '0;
        end else begin
            if (idx == 6'd0 || raw_h > PROD_W'(ROWS)) height = H_W'(ROWS);
            else                                      height = H_W'(raw_h);
            shade = hit_id >> shift;
        end
    end
endmodule

// File: rtl/raycol_engine.sv
`timescale 1ns/1ps
// Raycast column engine top. Captures player position and angle on a
// start pulse, then for each column launches one ray through the walker,
// converts its result to height and shade, and emits one result beat.
// Pulses frame_done after the last column. Start is ignored while busy.
module raycol_engine
    import raycol_pkg::*;
#(
    parameter int COLS       = 160,
    parameter int ROWS       = 120,
    parameter int STEP_LIMIT = 32,
    parameter int KF         = 240
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [11:0]                 pos_x,
    input  logic [11:0]                 pos_y,
    input  logic [7:0]                  view_ang,
    output logic                        col_valid,
    output logic [$clog2(COLS)-1:0]     col_num,
    output logic [$clog2(ROWS+1)-1:0]   col_height,
    output logic [3:0]                  col_shade,
    output logic [3:0]                  col_wall,
    output logic                        frame_done
);
    localparam int COL_W = $clog2(COLS);
    localparam int H_W   = $clog2(ROWS + 1);
    localparam int SPAN  = COLS / 8;
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    seq_state_t        state;
    logic [COL_W-1:0]  col;
    logic [POS_W-1:0]  lp_x, lp_y;
    logic [7:0]        l_ang;
    logic [7:0]        ray_ang;

    logic [MAG_W-1:0]  sin_mag, cos_mag;
    logic              sin_neg, cos_neg;
    logic              w_fin, w_yside;
    logic [DIST_W-1:0] w_perp;
    logic [CELL_W-1:0] w_id;
    logic [H_W-1:0]    s_height;
    logic [CELL_W-1:0] s_shade;

    // Per-column ray angle: four columns share one angle step.
    assign ray_ang = l_ang + 8'(col >> 2) - 8'(SPAN);

    raycol_trig u_trig (
        .ray_ang (ray_ang),
        .sin_mag (sin_mag),
        .sin_neg (sin_neg),
        .cos_mag (cos_mag),
        .cos_neg (cos_neg)
    );

    raycol_walker #(.STEP_LIMIT(STEP_LIMIT)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (state == ST_LAUNCH),
        .pos_x   (lp_x),
        .pos_y   (lp_y),
        .cos_mag (cos_mag),
        .cos_neg (cos_neg),
        .sin_mag (sin_mag),
        .sin_neg (sin_neg),
        .fin     (w_fin),
        .perp    (w_perp),
        .y_side  (w_yside),
        .hit_id  (w_id)
    );

    raycol_shade #(.ROWS(ROWS), .KF(KF)) u_shade (
        .perp   (w_perp),
        .y_side (w_yside),
        .hit_id (w_id),
        .height (s_height),
        .shade  (s_shade)
    );

    // Column sequencer and registered result beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            col        <= '0;
            lp_x       <= '0;
            lp_y       <= '0;
            l_ang      <= '0;
            col_valid  <= 1'b0;
            col_num    <= '0;
            col_height <= '0;
            col_shade  <= '0;
            col_wall   <= '0;
            frame_done <= 1'b0;
        end else begin
            col_valid  <= 1'b0;
            frame_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        lp_x  <= pos_x;
                        lp_y  <= pos_y;
                        l_ang <= view_ang;
                        col   <= '0;
                        state <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: state <= ST_WAIT;
                ST_WAIT: begin
                    if (w_fin) begin
                        col_valid  <= 1'b1;
                        col_num    <= col;
                        col_height <= s_height;
                        col_shade  <= s_shade;
                        col_wall   <= w_id;
                        if (col == LAST_COL) begin
                            state <= ST_FINISH;
                        end else begin
                            col   <= col + COL_W'(1);
                            state <= ST_LAUNCH;
                        end
                    end
                end
                default: begin
                    frame_done <= 1'b1;
                    state      <= ST_IDLE;
                end
            endcase
        end
    end

    AST_BEAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |=> !col_valid); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ($past(col_valid) && $past(col_num) == LAST_COL)); // R3
    AST_HEIGHT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> col_height <= H_W'(ROWS)); // R7
    AST_SHADE_DIMS: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> col_shade <= col_wall); // R8
    AST_NO_WALL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_wall == 4'd0) |-> (col_height == '0 && col_shade == 4'd0)); // R9
    AST_INPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(l_ang) && $stable(lp_x) && $stable(lp_y))); // R10
endmodule

// File: tb/raycol_engine_tb_top.sv
`timescale 1ns/1ps
// Directed bench for raycol_engine: one task per scenario, each comparing
// every result beat against a behavioural model of the requirements.
module raycol_engine_tb_top;
    localparam int KF_TB = 240;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_m = 1'b0;
    logic        start_l = 1'b0;
    logic [11:0] px = '0;
    logic [11:0] py = '0;
    logic [7:0]  ang = '0;

    logic       m_valid, m_done, l_valid, l_done;
    logic [7:0] m_num, l_num;
    logic [6:0] m_h, l_h;
    logic [3:0] m_c, l_c, m_w, l_w;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    raycol_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start_m),
        .pos_x(px), .pos_y(py), .view_ang(ang),
        .col_valid(m_valid), .col_num(m_num), .col_height(m_h),
        .col_shade(m_c), .col_wall(m_w), .frame_done(m_done)
    );

    raycol_engine #(.STEP_LIMIT(3)) dut_lim_i (
        .clk(clk), .rst_n(rst_n), .start(start_l),
        .pos_x(px), .pos_y(py), .view_ang(ang),
        .col_valid(l_valid), .col_num(l_num), .col_height(l_h),
        .col_shade(l_c), .col_wall(l_w), .frame_done(l_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int qmag(input int i);
        int p;
        p = i * (128 - i);
        return (2032 * p) / (81920 - 4 * p);
    endfunction

    // R4: magnitude and sign of sine at angle a.
    task automatic sine_of(input int a, output int mag, output bit neg);
        int aa;
        int i;
        aa  = a & 255;
        i   = aa & 63;
        mag = ((aa >> 6) & 1) != 0 ? qmag(64 - i) : qmag(i);
        neg = ((aa >> 7) & 1) != 0;
    endtask

    // R5: map contents.
    function automatic int cellv(input int x, input int y);
        if (x == 0 || x == 15) return 9;
        if (y == 0 || y == 15) return 12;
        if ((x % 4) == 2 && (y % 4) == 2) return 6;
        return 0;
    endfunction

    // Behavioural model of one column (R4..R9).
    task automatic ref_column(input int x0, input int y0, input int a0, input int col,
                              input int lim, output int h, output int c, output int w);
        int ra, ms, mc, dxv, dyv, fx, fy, sdx, sdy, cx, cy, prev, d, idx, band, raw, ys;
        bit ns, nc, hit, far;
        ra = (a0 + (col >> 2) - 20) & 255;
        sine_of(ra, ms, ns);
        sine_of(ra + 64, mc, nc);
        dxv = (mc == 0) ? 65535 : 32512 / mc;                  // R6
        dyv = (ms == 0) ? 65535 : 32512 / ms;
        fx = x0 & 255; fy = y0 & 255;
        cx = (x0 >> 8) & 15; cy = (y0 >> 8) & 15;
        sdx = nc ? (fx * dxv) >> 8 : ((256 - fx) * dxv) >> 8;
        sdy = ns ? (fy * dyv) >> 8 : ((256 - fy) * dyv) >> 8;
        hit = 0; w = 0; prev = 0; ys = 0;
        for (int s = 0; s < lim && !hit; s++) begin
            if (sdx < sdy) begin
                prev = sdx; sdx += dxv; cx = nc ? (cx + 15) & 15 : (cx + 1) & 15; ys = 0;
            end else begin
                prev = sdy; sdy += dyv; cy = ns ? (cy + 15) & 15 : (cy + 1) & 15; ys = 1;
            end
            w = cellv(cx, cy);
            hit = (w != 0);
        end
        if (!hit) begin
            h = 0; c = 0; w = 0;                                 // R9
        end else begin
            d    = (prev > 65535) ? 65535 : prev;
            far  = d >= 4096;
            idx  = far ? 63 : (d >> 6);
            band = far ? 3 : ((d >> 10) & 3);
            raw  = (idx == 0) ? 0 : (KF_TB * (4096 / idx)) >> 12;
            h    = (idx == 0 || raw > 120) ? 120 : raw;          // R7
            c    = w >> (band + ys);                             // R8
        end
    endtask

    // One full frame on either instance, checking every beat and the done pulse.
    task automatic run_frame(input int x, input int y, input int a,
                             input bit use_lim, input bit disturb);
        int  lim, exp_col, eh, ec, ew, idle_beats;
        bit  fin, last_prev, v, dn;
        int  num, hh, cc, ww;
        lim = use_lim ? 3 : 32;
        exp_col = 0; fin = 0; last_prev = 0;
        @(negedge clk);
        px = 12'(x); py = 12'(y); ang = 8'(a);
        if (use_lim) start_l = 1'b1; else start_m = 1'b1;
        @(negedge clk);
        while (!fin) begin
            start_m = 1'b0; start_l = 1'b0;
            v  = use_lim ? l_valid : m_valid;
            dn = use_lim ? l_done  : m_done;
            num = use_lim ? int'(l_num) : int'(m_num);
            hh  = use_lim ? int'(l_h) : int'(m_h);
            cc  = use_lim ? int'(l_c) : int'(m_c);
            ww  = use_lim ? int'(l_w) : int'(m_w);
            if (dn) begin
                chk("R3 done follows column 159 beat", int'(last_prev), 1);
                chk("R2 beat count", exp_col, 160);
                fin = 1;
            end else if (last_prev) begin
                chk("R3 done missing after column 159", 0, 1);
                fin = 1;
            end
            if (v) begin
                ref_column(x, y, a, exp_col, lim, eh, ec, ew);
                chk("R2 column order", num, exp_col);
                chk(use_lim ? "R9 wall code" : "R5 wall code", ww, ew);
                chk(use_lim ? "R9 height" : "R7 height (R4 R6)", hh, eh);
                chk(use_lim ? "R9 shade" : "R8 shade", cc, ec);
                exp_col++;
                if (disturb && exp_col == 50) begin
                    // R10: new inputs and a start pulse mid-frame
                    px = 12'h880; py = 12'h880; ang = 8'(a + 77);
                    start_m = 1'b1;
                end
            end
            last_prev = v && (num == 159);
            @(negedge clk);
        end
        idle_beats = 0;
        for (int k = 0; k < 60; k++) begin
            if ((use_lim ? l_valid : m_valid) || (use_lim ? l_done : m_done)) idle_beats++;
            @(negedge clk);
        end
        chk("R10 no further frame after done", idle_beats, 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(m_valid), 0);
        chk("R1 done in reset", int'(m_done), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 valid idle", int'(m_valid), 0);
        chk("R1 done idle", int'(m_done), 0);
        chk("R1 height idle", int'(m_h), 0);
        chk("R1 shade idle", int'(m_c), 0);
        chk("R1 wall idle", int'(m_w), 0);
    endtask

    task automatic test_far_east();      run_frame(12'h180, 12'h880, 0,   0, 0); endtask
    task automatic test_pillar_field();  run_frame(12'h440, 12'hCC0, 100, 0, 0); endtask
    task automatic test_corner_room();   run_frame(12'h11A, 12'h1E6, 200, 0, 0); endtask
    task automatic test_grid_point();    run_frame(12'h300, 12'h500, 64,  0, 0); endtask
    task automatic test_close_clamp();   run_frame(12'h30D, 12'h280, 128, 0, 1); endtask
    task automatic test_step_limit();    run_frame(12'h880, 12'h880, 32,  1, 0); endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_far_east();
        test_pillar_field();
        test_corner_room();
        test_grid_point();
        test_close_clamp();
        test_step_limit();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule